// File: doc/BRIEF.md
# BCD Time-of-Day Register File

This block keeps calendar time in eight byte-wide registers: seconds, minutes, hours, a day register holding weekday and century flag, date, month, year and a control byte. All time fields are binary-coded decimal. They advance as a cascade of BCD counters, one step for each pulse on a one-second tick input. The cascade follows month lengths and leap years. A host reaches the registers through a synchronous byte port with a 3-bit address and separate write and read strobes.

Every write is checked against the legal range of its field, and a value outside that range is dropped without any indication. Bit 7 of the seconds register is a stop flag. While it is set the clock is frozen, and clearing it lets the clock resume from the frozen value. The design holds the register state itself, so nothing has to be recovered when counting resumes.

Top module: `tod_regfile`

## Requirements
- R1: After reset the registers read seconds 0x00, minutes 0x00, hours 0x00, day 0x01, date 0x01, month 0x01, year 0x00, control 0x90. Register addresses are 0 seconds, 1 minutes, 2 hours, 3 day, 4 date, 5 month, 6 year, 7 control.
- R2: A seconds write loads bits 6:0 only when they form valid BCD 00..59; otherwise the seconds stay as they were. Bit 7 of the written byte always loads the stop flag, whether or not the seconds value is accepted. A seconds read returns {stop, seconds}.
- R3: While the stop flag is 1, ticks do not change any time field. After the flag is cleared, counting resumes from the held value.
- R4: A minutes write uses bits 6:0 and is accepted only for BCD 00..59. An hours write uses bits 5:0 and is accepted only for BCD 00..23. A value with a units digit above 9 is rejected.
- R5: A date write uses bits 5:0 and is accepted only for BCD 01..31; zero is ignored. A month write uses bits 4:0 and is accepted only for BCD 01..12.
- R6: A year write takes the whole byte and is accepted only when both digits are 0..9.
- R7: A day write stores the weekday from bits 2:0 and the century flag from bit 6. A read returns the century flag in bit 6 ORed with the weekday in bits 2:0; all other bits read 0.
- R8: A control write stores the byte with bit 5 cleared and bits 7 and 4 set.
- R9: Each tick with the stop flag clear adds one second. The carries run seconds 59 to 00, minutes 59 to 00, hours 23 to 00, month 12 to 01 and year 99 to 00. At midnight the weekday goes 7 to 1, otherwise up by one.
- R10: The date rolls to 01 after day 31, 30 or 28 depending on the month. February has 29 days when the BCD year is divisible by 4, and year 00 counts as a leap year.
- R11: A write to any time register (addresses 0..6) in the same cycle as a tick takes precedence, and that tick is lost. With no tick and no write the time holds.
- R12: rdData takes the addressed register value on the clock edge where rdEn is high and keeps it while rdEn is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle pulse, once per second |
| wrEn | input | 1 | Write strobe |
| addr | input | 3 | Register address for reads and writes |
| wrData | input | 8 | Write byte |
| rdEn | input | 1 | Read strobe |
| rdData | output | 8 | Registered read byte |

## Verification
The bench drives the carry chain across February 28 in a leap year and in a common year, across April 30, and across the new year at 99. A wrong month-length or leap decode would land on an impossible date such as Feb 30 or skip Feb 29. It writes out-of-range and non-decimal values to every field. A design with a loose range check would then read back a corrupted time. It sets the stop flag and ticks, then clears the flag with an invalid seconds value. This catches a design that keeps counting while stopped or ties the stop flag to the seconds check. It also collides a write with a tick, where a design without write precedence would advance the seconds.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned REG_N = 8;
  localparam int unsigned ADDR_W = $clog2(REG_N);

  typedef enum logic [ADDR_W-1:0] {
    REG_SEC  = 3'd0,
    REG_MIN  = 3'd1,
    REG_HOUR = 3'd2,
    REG_DAY  = 3'd3,
    REG_DATE = 3'd4,
    REG_MON  = 3'd5,
    REG_YEAR = 3'd6,
    REG_CTRL = 3'd7
  } todReg_e;

  // strobes from control to datapath
  typedef struct packed {
    logic ldSec;
    logic ldStop;
    logic ldMin;
    logic ldHour;
    logic ldDay;
    logic ldDate;
    logic ldMon;
    logic ldYear;
    logic ldCtrl;
    logic advance;
    logic [BYTE_W-1:0] val;
  } todStrobe_t;

  typedef struct packed {
    logic stop;
    logic [6:0] sec;
    logic [6:0] min;
    logic [5:0] hour;
    logic cent;
    logic [2:0] wday;
    logic [5:0] date;
    logic [4:0] mon;
    logic [7:0] year;
    logic [7:0] ctrl;
  } todState_t;

  function automatic logic bcdOk(input logic [7:0] v, input logic [7:0] maxV);
    return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9) && (v <= maxV);
  endfunction

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  // divisible by 4: even tens with units 0/4/8, odd tens with units 2/6
  function automatic logic isLeap(input logic [7:0] y);
    if (!y[4]) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
  endfunction

  function automatic logic [7:0] monthLen(input logic [4:0] m, input logic leap);
    case (m)
      5'h02: return leap ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/tod_ctrl.sv
module tod_ctrl
  import tod_pkg::*;
(
  input  logic              tick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              stopQ,
  output todStrobe_t        strb
);
  logic [7:0] secV, minV, hourV, dateV, monV;
  logic timeWr;

  assign secV  = {1'b0, wrData[6:0]};
  assign minV  = {1'b0, wrData[6:0]};
  assign hourV = {2'b0, wrData[5:0]};
  assign dateV = {2'b0, wrData[5:0]};
  assign monV  = {3'b0, wrData[4:0]};
  assign timeWr = wrEn && (todReg_e'(addr) != REG_CTRL);

  always_comb begin
    strb = '0;
    strb.val = wrData;
    if (wrEn) begin
      case (todReg_e'(addr))
        REG_SEC: begin
          strb.ldStop = 1'b1;
          strb.ldSec  = bcdOk(secV, 8'h59);
        end
        REG_MIN:  strb.ldMin  = bcdOk(minV, 8'h59);
        REG_HOUR: strb.ldHour = bcdOk(hourV, 8'h23);
        REG_DAY:  strb.ldDay  = 1'b1;
        REG_DATE: strb.ldDate = bcdOk(dateV, 8'h31) && (dateV != 8'h00);
        REG_MON:  strb.ldMon  = bcdOk(monV, 8'h12) && (monV != 8'h00);
        REG_YEAR: strb.ldYear = bcdOk(wrData, 8'h99);
        default:  strb.ldCtrl = 1'b1;
      endcase
    end
    strb.advance = tick && !stopQ && !timeWr;
  end
endmodule

// File: rtl/tod_datapath.sv
module tod_datapath
  import tod_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  todStrobe_t        strb,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output todState_t         st,
  output logic [BYTE_W-1:0] rdData
);
  logic [7:0] secInc, minInc, hourInc, dateInc, monInc, yearInc;
  logic secWrap, minWrap, hourWrap, dateWrap, monWrap, yearWrap;
  logic dayCarry;

  assign secInc  = bcdInc({1'b0, st.sec});
  assign minInc  = bcdInc({1'b0, st.min});
  assign hourInc = bcdInc({2'b0, st.hour});
  assign dateInc = bcdInc({2'b0, st.date});
  assign monInc  = bcdInc({3'b0, st.mon});
  assign yearInc = bcdInc(st.year);

  assign secWrap  = st.sec == 7'h59;
  assign minWrap  = st.min == 7'h59;
  assign hourWrap = st.hour == 6'h23;
  assign dateWrap = {2'b0, st.date} >= monthLen(st.mon, isLeap(st.year));
  assign monWrap  = st.mon == 5'h12;
  assign yearWrap = st.year == 8'h99;
  assign dayCarry = secWrap && minWrap && hourWrap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st <= '{stop: 1'b0, sec: '0, min: '0, hour: '0, cent: 1'b0,
              wday: 3'd1, date: 6'h01, mon: 5'h01, year: '0, ctrl: 8'h90};
    end else begin
      if (strb.advance) begin
        st.sec <= secWrap ? 7'h00 : secInc[6:0];
        if (secWrap) st.min <= minWrap ? 7'h00 : minInc[6:0];
        if (secWrap && minWrap) st.hour <= hourWrap ? 6'h00 : hourInc[5:0];
        if (dayCarry) begin
          st.wday <= (st.wday == 3'd7) ? 3'd1 : st.wday + 3'd1;
          st.date <= dateWrap ? 6'h01 : dateInc[5:0];
          if (dateWrap) begin
            st.mon <= monWrap ? 5'h01 : monInc[4:0];
            if (monWrap) st.year <= yearWrap ? 8'h00 : yearInc;
          end
        end
      end
      if (strb.ldSec)  st.sec  <= strb.val[6:0];
      if (strb.ldStop) st.stop <= strb.val[7];
      if (strb.ldMin)  st.min  <= strb.val[6:0];
      if (strb.ldHour) st.hour <= strb.val[5:0];
      if (strb.ldDay) begin
        st.wday <= strb.val[2:0];
        st.cent <= strb.val[6];
      end
      if (strb.ldDate) st.date <= strb.val[5:0];
      if (strb.ldMon)  st.mon  <= strb.val[4:0];
      if (strb.ldYear) st.year <= strb.val;
      if (strb.ldCtrl) st.ctrl <= (strb.val & 8'h5F) | 8'h90;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else if (rdEn) begin
      case (todReg_e'(rdAddr))
        REG_SEC:  rdData <= {st.stop, st.sec};
        REG_MIN:  rdData <= {1'b0, st.min};
        REG_HOUR: rdData <= {2'b0, st.hour};
        REG_DAY:  rdData <= {1'b0, st.cent, 3'b0, st.wday};
        REG_DATE: rdData <= {2'b0, st.date};
        REG_MON:  rdData <= {3'b0, st.mon};
        REG_YEAR: rdData <= st.year;
        default:  rdData <= st.ctrl;
      endcase
    end
  end
endmodule

// File: rtl/tod_regfile.sv
module tod_regfile
  import tod_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              rdEn,
  output logic [BYTE_W-1:0] rdData
);
  todStrobe_t strb;
  todState_t  curState;

  tod_ctrl u_ctrl (
    .tick   (tick),
    .wrEn   (wrEn),
    .addr   (addr),
    .wrData (wrData),
    .stopQ  (curState.stop),
    .strb   (strb)
  );

  tod_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .rdEn   (rdEn),
    .rdAddr (addr),
    .st     (curState),
    .rdData (rdData)
  );
endmodule

// File: rtl/tod_regfile_chk.sv
module tod_regfile_chk
  import tod_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              tick,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic              rdEn,
  input logic [BYTE_W-1:0] rdData,
  input todState_t         st
);
  a_r2_sec_legal: assert property (@(posedge clk) disable iff (!rstN)
    (st.sec[3:0] <= 4'd9) && (st.sec <= 7'h59));

  a_r3_stop_freezes: assert property (@(posedge clk) disable iff (!rstN)
    (st.stop && !wrEn) |=> $stable(st));

  a_r5_date_month_legal: assert property (@(posedge clk) disable iff (!rstN)
    (st.date != 6'h00) && (st.mon != 5'h00) && (st.mon <= 5'h12));

  a_r8_ctrl_forced_bits: assert property (@(posedge clk) disable iff (!rstN)
    st.ctrl[7] && !st.ctrl[5] && st.ctrl[4]);

  a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !wrEn) |=> $stable(st));

  a_r12_year_read: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wrEn && todReg_e'(addr) == REG_YEAR) |=> rdData == $past(st.year));

  a_r12_read_hold: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));
endmodule

bind tod_regfile tod_regfile_chk u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .tick   (tick),
  .wrEn   (wrEn),
  .addr   (addr),
  .rdEn   (rdEn),
  .rdData (rdData),
  .st     (curState)
);

// File: tb/sim_tod_regfile.sv
module sim_tod_regfile;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wrData = '0;
  logic rdEn = 1'b0;
  logic [7:0] rdData;
  int nChk = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  tod_regfile u0 (.clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .addr(addr),
                  .wrData(wrData), .rdEn(rdEn), .rdData(rdData));

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    nChk++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); rdEn = 1'b1; addr = a;
    @(negedge clk); rdEn = 1'b0;
    check(tag, rdData, exp);
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic setAll(input logic [7:0] y, input logic [7:0] m, input logic [7:0] d,
                        input logic [7:0] wd);
    wr(3'd6, y); wr(3'd5, m); wr(3'd4, d); wr(3'd3, wd);
    wr(3'd2, 8'h23); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
  endtask

  task automatic testReset();
    rd(3'd0, 8'h00, "R1 sec"); rd(3'd1, 8'h00, "R1 min"); rd(3'd2, 8'h00, "R1 hour");
    rd(3'd3, 8'h01, "R1 day"); rd(3'd4, 8'h01, "R1 date"); rd(3'd5, 8'h01, "R1 mon");
    rd(3'd6, 8'h00, "R1 year"); rd(3'd7, 8'h90, "R1 ctrl");
  endtask

  task automatic testValidWrites();
    wr(3'd0, 8'h45); rd(3'd0, 8'h45, "R2 sec write");
    wr(3'd1, 8'h30); rd(3'd1, 8'h30, "R4 min write");
    wr(3'd2, 8'h22); rd(3'd2, 8'h22, "R4 hour write");
    wr(3'd4, 8'h31); rd(3'd4, 8'h31, "R5 date write");
    wr(3'd5, 8'h12); rd(3'd5, 8'h12, "R5 month write");
    wr(3'd6, 8'h87); rd(3'd6, 8'h87, "R6 year write");
  endtask

  task automatic testInvalidWrites();
    wr(3'd0, 8'h60); rd(3'd0, 8'h45, "R2 sec 60 ignored");
    wr(3'd1, 8'h5A); rd(3'd1, 8'h30, "R4 min non-BCD ignored");
    wr(3'd2, 8'h24); rd(3'd2, 8'h22, "R4 hour 24 ignored");
    wr(3'd4, 8'h00); rd(3'd4, 8'h31, "R5 date zero ignored");
    wr(3'd4, 8'h32); rd(3'd4, 8'h31, "R5 date 32 ignored");
    wr(3'd5, 8'h13); rd(3'd5, 8'h12, "R5 month 13 ignored");
    wr(3'd5, 8'h00); rd(3'd5, 8'h12, "R5 month zero ignored");
    wr(3'd6, 8'hA0); rd(3'd6, 8'h87, "R6 year non-BCD ignored");
  endtask

  task automatic testDayCentury();
    wr(3'd3, 8'h45); rd(3'd3, 8'h45, "R7 century+weekday");
    wr(3'd3, 8'hFF); rd(3'd3, 8'h47, "R7 masked bits");
  endtask

  task automatic testCtrl();
    wr(3'd7, 8'h2F); rd(3'd7, 8'h9F, "R8 ctrl forced");
    wr(3'd7, 8'h00); rd(3'd7, 8'h90, "R8 ctrl zero");
  endtask

  task automatic testLeap();
    setAll(8'h24, 8'h02, 8'h28, 8'h07);
    pulse(1);
    rd(3'd0, 8'h00, "R9 sec wrap"); rd(3'd1, 8'h00, "R9 min wrap");
    rd(3'd2, 8'h00, "R9 hour wrap"); rd(3'd3, 8'h01, "R9 weekday 7 to 1");
    rd(3'd4, 8'h29, "R10 leap Feb 29");
    wr(3'd2, 8'h23); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    pulse(1);
    rd(3'd4, 8'h01, "R10 leap Feb end"); rd(3'd5, 8'h03, "R10 leap to March");
    rd(3'd3, 8'h02, "R9 weekday step");
  endtask

  task automatic testMonthEnds();
    setAll(8'h23, 8'h02, 8'h28, 8'h03);
    pulse(1);
    rd(3'd4, 8'h01, "R10 common Feb 28 rolls"); rd(3'd5, 8'h03, "R10 common to March");
    setAll(8'h23, 8'h04, 8'h30, 8'h03);
    pulse(1);
    rd(3'd4, 8'h01, "R10 April 30 rolls"); rd(3'd5, 8'h05, "R10 to May");
    setAll(8'h99, 8'h12, 8'h31, 8'h03);
    pulse(1);
    rd(3'd4, 8'h01, "R9 new year date"); rd(3'd5, 8'h01, "R9 new year month");
    rd(3'd6, 8'h00, "R9 year 99 wraps");
  endtask

  task automatic testStop();
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h90);
    pulse(3);
    rd(3'd0, 8'h90, "R3 frozen while stopped");
    rd(3'd1, 8'h00, "R3 minutes frozen");
    wr(3'd0, 8'h7F);
    rd(3'd0, 8'h10, "R2 stop cleared with invalid seconds");
    pulse(1);
    rd(3'd0, 8'h11, "R3 resumes from held value");
  endtask

  task automatic testCollision();
    wr(3'd0, 8'h05);
    @(negedge clk); wrEn = 1'b1; addr = 3'd1; wrData = 8'h10; tick = 1'b1;
    @(negedge clk); wrEn = 1'b0; tick = 1'b0;
    rd(3'd0, 8'h05, "R11 tick lost on write");
    rd(3'd1, 8'h10, "R11 write applied");
    repeat (3) @(negedge clk);
    rd(3'd0, 8'h05, "R11 no tick holds");
    pulse(1);
    rd(3'd0, 8'h06, "R9 plain tick advances");
  endtask

  task automatic testReadHold();
    rd(3'd6, 8'h00, "R12 read year");
    @(negedge clk); addr = 3'd7;
    @(negedge clk);
    check("R12 rdData held without rdEn", rdData, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testValidWrites();
    testInvalidWrites();
    testDayCentury();
    testCtrl();
    testLeap();
    testMonthEnds();
    testStop();
    testCollision();
    testReadHold();
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    #800000;
    nChk++;
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule